// File: doc/BRIEF.md
# Shared-Ramp Column-Parallel Converter Controller

This block is the digital half of a column-parallel single-slope converter. One 8-bit sweep counter drives a shared ramp, either as a DAC code or as the pacing reference for an external constant-current ramp. Each channel has its own comparator input from an analog threshold element. Each channel also has a code register that latches the counter value when that comparator switches. Only the per-channel capture logic is replicated; the counter, the ramp and the sweep sequencing exist once.

Two sweep modes exist. In reset-ramp mode every sweep counts up from 0 to 255 and is followed by one reset cycle in which the ramp is discharged. In alternating mode, sweeps go up and down in turn with no reset cycle, and a channel captures on its comparator turning off during a down sweep. Comparator inputs are asynchronous. Each one passes through a two-flop synchronizer, and the counter is delayed by the same amount so that a code names the count the comparator was sampled against. A one-cycle end-of-sweep pulse tells the consumer when all codes are settled.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While a sweep runs, `ramp_code` changes by exactly one on every clock: up sweeps go 0,1,...,255 with `ramp_up`=1, and down sweeps go 255,254,...,0 with `ramp_up`=0.
- R2: With no accepted `start`, the counter holds its value and `busy` stays 0. A `start` sampled while a sweep runs is ignored, except in the final count cycle of an alternating-mode sweep. `pingpong` is sampled together with an accepted `start`.
- R3: In reset-ramp mode (`pingpong`=0 at start) the sweep always counts up. The clock after count 255 is a single reset cycle with `discharge`=1, `busy`=1 and `ramp_code`=0. A `start` held high launches the next sweep straight after it, giving a 257-cycle frame.
- R4: In alternating mode (`pingpong`=1) each sweep runs opposite to the previous one. The first alternating sweep after reset or after a reset-ramp frame counts up. `discharge` stays 0. A `start` held through the last count begins the next sweep on the following clock, giving a 256-cycle frame; the turnaround count (255 or 0) is therefore output twice.
- R5: In an up sweep, a channel's code is the count k whose sampling edge first saw its comparator high, either as a low-to-high change or because it was already high at the sweep's first count. A comparator model `cmp = (ramp_code >= T)` therefore yields code T for T in 0..255.
- R6: In a down sweep, a channel's code is the count whose sampling edge first saw its comparator low, either as a high-to-low change or because it was already low at the first count. The same model yields T-1 for T in 1..256.
- R7: After a channel captures in a sweep, further comparator transitions in that sweep do not change its code or valid flag.
- R8: A channel that captures sets `ch_valid`=1. A channel that does not capture in a sweep reports code 255 after an up sweep and code 0 after a down sweep, with `ch_valid`=0.
- R9: `frame_done` is a one-cycle pulse in the third cycle after a sweep's last count cycle, that is 258 cycles after the sweep's first count cycle. All codes and valid flags of that sweep are visible while it is high.
- R10: After reset, `ramp_code`=0, `busy`=0, `discharge`=0, `frame_done`=0, and all codes and valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to launch a sweep |
| pingpong | input | 1 | Mode for the launched sweep: 1 alternating, 0 reset-ramp |
| cmp_in | input | NCH | Asynchronous comparator outputs, one per channel |
| ramp_code | output | W | Shared sweep count to the DAC or ramp pacing |
| ramp_up | output | 1 | Sweep direction, 1 while counting up |
| busy | output | 1 | Sweep or reset cycle in progress |
| discharge | output | 1 | Ramp discharge strobe during the reset cycle |
| frame_done | output | 1 | One-cycle end-of-sweep pulse |
| ch_code | output | NCH*W | Per-channel captured codes, channel c in bits c*W+W-1..c*W |
| ch_valid | output | NCH | Per-channel capture flag for the last sweep |

## Verification
The hardest situations to reach are comparator chatter after a capture and the alternating-mode turnaround, where the last count of one sweep and the first count of the next overlap the synchronizer delay. The comparator model in the bench can invert its output for one cycle a few counts past the threshold. This produces a second edge that a correct design must ignore. `start` is held through sweep ends to force the zero-gap turnaround and the reset-cycle restart. Thresholds of 0, 1, 255 and 256 place the crossing at the first count, at the last count, or nowhere in the sweep.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int NCH = 4,
  parameter int W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pingpong,
  input  logic [NCH-1:0]   cmp_in,
  output logic [W-1:0]     ramp_code,
  output logic             ramp_up,
  output logic             busy,
  output logic             discharge,
  output logic             frame_done,
  output logic [NCH*W-1:0] ch_code,
  output logic [NCH-1:0]   ch_valid
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt, c1, c2;
  logic up, run, rcyc, pp;
  logic [NCH-1:0] s1, s2, s3, lock;
  // tag bits: [3] active, [2] first count, [1] last count, [0] up
  logic [3:0] tg1, tg2;

  logic at_end, at_first, take, nd;
  assign at_end   = run && (up ? cnt == TOP : cnt == '0);
  assign at_first = run && (up ? cnt == '0  : cnt == TOP);
  assign take     = start && (!run || (pp && at_end));
  assign nd       = pingpong ? ~up : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; up <= 1'b0; run <= 1'b0; rcyc <= 1'b0; pp <= 1'b0;
    end else begin
      rcyc <= 1'b0;
      if (take) begin
        run <= 1'b1;
        pp  <= pingpong;
        up  <= nd;
        cnt <= nd ? '0 : TOP;
      end else if (at_end) begin
        run <= 1'b0;
        if (!pp) begin
          rcyc <= 1'b1;
          cnt  <= '0;
          up   <= 1'b0;
        end
      end else if (run) begin
        cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      c1 <= '0; c2 <= '0; tg1 <= '0; tg2 <= '0;
    end else begin
      s1 <= cmp_in; s2 <= s1; s3 <= s2;
      c1 <= cnt;    c2 <= c1;
      tg1 <= {run, at_first, at_end, up};
      tg2 <= tg1;
    end
  end

  logic [NCH-1:0] prev, hit, grab;
  assign prev = tg2[2] ? {NCH{~tg2[0]}} : s3;
  assign hit  = !tg2[3] ? '0 : (tg2[0] ? (s2 & ~prev) : (~s2 & prev));
  assign grab = hit & (tg2[2] ? {NCH{1'b1}} : ~lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock       <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= tg2[3] & tg2[1];
      if (tg2[3]) lock <= tg2[2] ? hit : (lock | hit);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] q;
    logic         v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        v <= 1'b0;
      end else if (grab[i]) begin
        q <= c2;
        v <= 1'b1;
      end else if (tg2[3] && tg2[1] && !lock[i]) begin
        q <= tg2[0] ? TOP : '0;
        v <= 1'b0;
      end
    end
    assign ch_code[i*W +: W] = q;
    assign ch_valid[i]       = v;
  end

  assign ramp_code = cnt;
  assign ramp_up   = up;
  assign busy      = run | rcyc;
  assign discharge = rcyc;
endmodule

module ramp_adc_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ramp_code,
  input logic         ramp_up,
  input logic         busy,
  input logic         discharge,
  input logic         frame_done
);
  localparam logic [W-1:0] TOP = '1;

  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ramp_up && !discharge && ramp_code != '0) |->
      ramp_code == W'($past(ramp_code) + 1'b1));

  a_r1_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ramp_up && !discharge && ramp_code != TOP) |->
      ramp_code == W'($past(ramp_code) - 1'b1));

  a_r3_discharge_after_top: assert property (@(posedge clk) disable iff (!rst_n)
    discharge |-> (ramp_code == '0 && $past(ramp_code) == TOP && !$past(discharge)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(ramp_code));
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ramp_code(ramp_code), .ramp_up(ramp_up),
  .busy(busy), .discharge(discharge), .frame_done(frame_done));

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb;
  localparam int NCH = 4;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rst_n, start, pingpong;
  logic [NCH-1:0] cmp_in;
  logic [W-1:0] ramp_code;
  logic ramp_up, busy, discharge, frame_done;
  logic [NCH*W-1:0] ch_code;
  logic [NCH-1:0] ch_valid;

  int checks = 0;
  int errors = 0;
  int thr[NCH];
  int gl_at[NCH];
  bit next_pp_up = 1'b1;

  always #2 clk = ~clk;

  ramp_adc_ctrl #(.NCH(NCH), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pingpong(pingpong),
    .cmp_in(cmp_in), .ramp_code(ramp_code), .ramp_up(ramp_up),
    .busy(busy), .discharge(discharge), .frame_done(frame_done),
    .ch_code(ch_code), .ch_valid(ch_valid));

  // analog comparator model with optional one-cycle chatter
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++)
      cmp_in[c] <= (int'(ramp_code) >= thr[c]) ^
                   (busy && !discharge && int'(ramp_code) == gl_at[c]);
  end

  function automatic int exp_code(int t, bit up);
    if (up) return (t <= 255) ? t : 255;
    return (t >= 1) ? t - 1 : 0;
  endfunction

  function automatic int exp_valid(int t, bit up);
    if (up) return (t <= 255) ? 1 : 0;
    return (t >= 1) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sweep(bit ppm, bit glitch);
    bit up = ppm ? next_pp_up : 1'b1;
    for (int c = 0; c < NCH; c++)
      gl_at[c] = !glitch ? -10 : (up ? thr[c] + 3 : thr[c] - 4);
    @(negedge clk); start = 1'b1; pingpong = ppm;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 260; i++) begin
      if (i < 256) begin
        chk("R1 ramp", int'(ramp_code), up ? i : 255 - i);
        chk("R1 dir", int'(ramp_up), int'(up));
      end
      if (i == 100) start = 1'b1;
      if (i == 101) start = 1'b0;
      if (i == 128) chk("R3 no discharge mid-sweep", int'(discharge), 0);
      if (i == 256) begin
        if (!ppm) begin
          chk("R3 discharge", int'(discharge), 1);
          chk("R3 reset ramp", int'(ramp_code), 0);
          chk("R3 busy", int'(busy), 1);
        end else begin
          chk("R4 no discharge", int'(discharge), 0);
          chk("R4 idle after sweep", int'(busy), 0);
        end
      end
      chk("R9 frame_done", int'(frame_done), (i == 258) ? 1 : 0);
      if (i == 258) begin
        for (int c = 0; c < NCH; c++) begin
          chk(glitch ? "R7 code" : (up ? "R5 code" : "R6 code"),
              int'(ch_code[c*W +: W]), exp_code(thr[c], up));
          chk("R8 valid", int'(ch_valid[c]), exp_valid(thr[c], up));
        end
      end
      if (i == 259) begin
        chk("R2 mid-sweep start ignored", int'(busy), 0);
        chk("R2 idle hold", int'(ramp_code), (ppm && !up) ? 0 : (ppm ? 255 : 0));
      end
      @(negedge clk);
    end
    next_pp_up = ppm ? !up : 1'b1;
  endtask

  task automatic b2b(bit ppm);
    bit up = ppm ? next_pp_up : 1'b1;
    int per = ppm ? 256 : 257;
    int pulses = 0;
    for (int c = 0; c < NCH; c++) gl_at[c] = -10;
    @(negedge clk); start = 1'b1; pingpong = ppm;
    @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      if (i == 300) start = 1'b0;
      if (frame_done) begin
        pulses++;
        chk(ppm ? "R4 frame period" : "R3 frame period", i,
            (pulses == 1) ? 258 : 258 + per);
      end
      if (!ppm && i == 257) chk("R3 restart ramp", int'(ramp_code), 0);
      if (!ppm && i == 258) chk("R3 restart step", int'(ramp_code), 1);
      if (ppm && i == 256) begin
        chk("R4 turnaround", int'(ramp_code), up ? 255 : 0);
        chk("R4 turnaround dir", int'(ramp_up), up ? 0 : 1);
        chk("R4 no reset cycle", int'(discharge), 0);
      end
      if (ppm && i == 257) chk("R4 turnaround step", int'(ramp_code), up ? 254 : 1);
      @(negedge clk);
    end
    chk("R9 pulse count", pulses, 2);
    next_pp_up = ppm ? up : 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; pingpong = 1'b0;
    for (int c = 0; c < NCH; c++) begin thr[c] = 300; gl_at[c] = -10; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ramp", int'(ramp_code), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 discharge", int'(discharge), 0);
    chk("R10 frame_done", int'(frame_done), 0);
    chk("R10 valid", int'(ch_valid), 0);
    chk("R10 codes", int'(ch_code), 0);
    repeat (20) @(negedge clk);
    chk("R2 no start hold", int'(ramp_code), 0);
    chk("R2 no start busy", int'(busy), 0);

    thr[0] = 0; thr[1] = 255; thr[2] = 256; thr[3] = 128;
    sweep(1'b0, 1'b1);
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < NCH; c++) thr[c] = $urandom_range(256, 0);
      sweep(1'b0, 1'b0);
    end
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < NCH; c++) thr[c] = $urandom_range(256, 0);
      sweep(1'b1, k[0]);
    end
    thr[0] = 0; thr[1] = 1; thr[2] = 256; thr[3] = 255;
    sweep(1'b1, 1'b1);
    for (int c = 0; c < NCH; c++) thr[c] = $urandom_range(256, 0);
    sweep(1'b0, 1'b0);
    sweep(1'b1, 1'b1);
    b2b(1'b0);
    b2b(1'b1);
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < NCH; c++) thr[c] = $urandom_range(256, 0);
      sweep(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule